// File: doc/BRIEF.md
# Four-channel match timer

This block holds four 32-bit timer counters behind a small synchronous register bus that runs on the peripheral clock. The four counters share one prescaler. Each counter has its own enable bit, hold-in-reset bit, count direction, match value and three match actions. A match can raise an interrupt flag, return the counter to zero, or stop the counter by clearing its own enable bit. One level interrupt output is high while any flag is set.

Software reaches every register at four aliased word offsets. Bits [3:2] of the address choose the write style: 0 is a plain write, 1 ORs the data in, 2 clears the bits that are 1 in the data, and 3 toggles them. A read returns the register at any of its four aliases. A typical use is a periodic tick: the counter is set to return to zero and raise a flag on match. A one-shot use sets the stop action, so the counter parks at its match value.

Top module: `mtimer_top`

## Requirements
- R1: Address bits [7:4] select a register, and bits [3:2] select the write style. Style 0 replaces the register, 1 ORs in the write data, 2 clears the bits set in the data, and 3 XORs the data in. Reads return the register at any of the four styles. This applies to control (0x10), direction (0x20), prescale (0x70), match control (0x90) and the match values (0xA0 + 0x10·n).
- R2: Control bit n (n = 0..3) enables counter n. While the bit is 0 and the hold bit is 0, the counter keeps its value. While it is 1, the counter advances once on each prescaler tick.
- R3: Control bit 4+n holds counter n at zero. The counter reads 0 from the edge after the bit is set, and it stays at 0 while the bit is 1, even when enabled. After the bit is cleared, an enabled counter resumes counting from 0.
- R4: The direction field of counter n sits at bits [4n+3:4n]. Code 1 counts down, wrapping from 0 to 0xFFFFFFFF. Every other code counts up, wrapping from 0xFFFFFFFF to 0.
- R5: The prescale register (0x70) holds a limit P. The prescale counter (read-only, 0x80) runs 0..P while any counter is active and is at 0 while none is active. Counters advance on the edge where the prescale counter wraps, so they advance every edge when P is 0 and every P+1 edges otherwise.
- R6: A match is an advancing edge on which counter n equals its match value. Match control bit 3n raises the flag, bit 3n+1 makes the counter go to 0, and bit 3n+2 clears enable bit n and keeps the counter at the match value unless bit 3n+1 is also set. Without bit 3n+1 or bit 3n+2, the counter advances normally.
- R7: Interrupt flag n sits at bit n of register 0x00. It is set only by a match with bit 3n enabled, so a counter wrap alone never sets it. A plain-style write of 1 clears a flag, and the OR, clear and XOR styles work as in R1. Bits 4 and up read 0. A match wins over a clear on the same edge.
- R8: The interrupt output is high exactly while at least one flag bit is set.
- R9: The counter values at 0x30 + 0x10·n and the prescale counter are read-only, and writes to them are ignored. Addresses 0xE0..0xFF, and any address whose bits [1:0] are nonzero, read 0 and ignore writes.
- R10: After reset, every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; [7:4] register, [3:2] write style |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt, OR of the flag bits |

## Verification
The hardest situations to reach are the match edges, because the counters cannot be loaded from the bus. The stimulus approaches the interesting values by counting. It counts down from zero to reach the wrap at 0xFFFFFFFF, with the interrupt enabled and a match value far away, and it counts up from there to reach the wrap back to zero. It arms the stop action on a small match value to catch the single edge where the enable clears. The prescaled case is caught mid-cycle by reading the prescale counter at a known offset from the enable write. A behavioural model tracks every register on every clock, so the read data of whatever address is on the bus is compared each cycle.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int TIMER_W = 32;
    localparam int CH_N    = 4;
    localparam int ADDR_W  = 8;
    localparam int DIR_FW  = 4;
    localparam int ACT_W   = 3;

    localparam logic [3:0] SEL_FLAG = 4'h0;
    localparam logic [3:0] SEL_CTRL = 4'h1;
    localparam logic [3:0] SEL_DIR  = 4'h2;
    localparam logic [3:0] SEL_CNT0 = 4'h3;
    localparam logic [3:0] SEL_PRE  = 4'h7;
    localparam logic [3:0] SEL_PCNT = 4'h8;
    localparam logic [3:0] SEL_MCTL = 4'h9;
    localparam logic [3:0] SEL_MAT0 = 4'hA;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic [2*CH_N-1:0]                ctrl;
        logic [DIR_FW*CH_N-1:0]           dir;
        logic [TIMER_W-1:0]               pre;
        logic [ACT_W*CH_N-1:0]            mctl;
        logic [CH_N-1:0][TIMER_W-1:0]     mat;
        logic [CH_N-1:0]                  flag;
    } regs_t;

    // Combine the current register value with bus data per write style.
    // w1c selects write-one-to-clear behaviour for the plain style.
    function automatic logic [TIMER_W-1:0] alias_merge(
        input logic [TIMER_W-1:0] cur,
        input logic [TIMER_W-1:0] wd,
        input alias_op_e          op,
        input logic               w1c
    );
        logic [TIMER_W-1:0] res;
        unique case (op)
            OP_WRITE:  res = w1c ? (cur & ~wd) : wd;
            OP_SET:    res = cur | wd;
            OP_CLEAR:  res = cur & ~wd;
            default:   res = cur ^ wd;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
    parameter int W = mtimer_pkg::TIMER_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] pcnt_o,
    output logic         tick_o
);
    logic [W-1:0] pcnt_d, pcnt_q;

    always_comb begin
        tick_o = run_i && (pcnt_q >= limit_i);
        if (!run_i || tick_o) pcnt_d = '0;
        else                  pcnt_d = pcnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    assign pcnt_o = pcnt_q;

    // R5: a tick edge always lands the prescale counter on zero
    p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pcnt_q == '0));

    // R5: with no active counter the prescale counter sits at zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pcnt_q == '0));
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel #(
    parameter int W = mtimer_pkg::TIMER_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic         down_i,
    input  logic [W-1:0] match_i,
    input  logic         zero_on_hit_i,
    input  logic         hold_on_hit_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] step;

    always_comb begin
        step  = down_i ? (cnt_q - W'(1)) : (cnt_q + W'(1));
        cnt_d = cnt_q;
        hit_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && tick_i) begin
            if (cnt_q == match_i) begin
                hit_o = 1'b1;
                if (zero_on_hit_i)      cnt_d = '0;
                else if (hold_on_hit_i) cnt_d = cnt_q;
                else                    cnt_d = step;
            end else begin
                cnt_d = step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3: the hold bit forces zero on the following edge
    p_clear_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R2: a disabled counter keeps its value
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(cnt_q));

    // R6: a match with the zero action returns the counter to zero
    p_hit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && zero_on_hit_i) |=> (cnt_q == '0));
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int CNT_W = TIMER_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int SEL_LSB = 4;

    regs_t st_d, st_q;

    logic [CH_N-1:0][CNT_W-1:0] cnt;
    logic [CH_N-1:0]            hit;
    logic [CH_N-1:0]            flag_set;
    logic [CH_N-1:0]            stop_vec;
    logic [CH_N-1:0]            run_vec;
    logic [CNT_W-1:0]           pcnt;
    logic                       tick;
    logic [3:0]                 sel;
    logic                       aligned;
    alias_op_e                  op;
    logic [CNT_W-1:0]           merged;

    assign sel     = bus_addr[SEL_LSB+3:SEL_LSB];
    assign op      = alias_op_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign run_vec = st_q.ctrl[CH_N-1:0] & ~st_q.ctrl[2*CH_N-1:CH_N];

    mtimer_prescale #(.W(CNT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (|run_vec),
        .limit_i (st_q.pre),
        .pcnt_o  (pcnt),
        .tick_o  (tick)
    );

    for (genvar n = 0; n < CH_N; n++) begin : g_ch
        mtimer_channel #(.W(CNT_W)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .tick_i        (tick),
            .run_i         (run_vec[n]),
            .clr_i         (st_q.ctrl[CH_N+n]),
            .down_i        (st_q.dir[DIR_FW*n +: DIR_FW] == DIR_FW'(1)),
            .match_i       (st_q.mat[n]),
            .zero_on_hit_i (st_q.mctl[ACT_W*n+1]),
            .hold_on_hit_i (st_q.mctl[ACT_W*n+2]),
            .cnt_o         (cnt[n]),
            .hit_o         (hit[n])
        );
        assign flag_set[n] = hit[n] & st_q.mctl[ACT_W*n];
        assign stop_vec[n] = hit[n] & st_q.mctl[ACT_W*n+2];

        // R6: the stop action leaves the enable bit cleared
        p_stop_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
            stop_vec[n] |=> !st_q.ctrl[n]);
    end

    // Read mux; also the "current value" for alias writes.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_FLAG: bus_rdata = CNT_W'(st_q.flag);
                SEL_CTRL: bus_rdata = CNT_W'(st_q.ctrl);
                SEL_DIR:  bus_rdata = CNT_W'(st_q.dir);
                SEL_PRE:  bus_rdata = st_q.pre;
                SEL_PCNT: bus_rdata = pcnt;
                SEL_MCTL: bus_rdata = CNT_W'(st_q.mctl);
                default:  bus_rdata = '0;
            endcase
            for (int n = 0; n < CH_N; n++) begin
                if (sel == 4'(int'(SEL_CNT0) + n)) bus_rdata = cnt[n];
                if (sel == 4'(int'(SEL_MAT0) + n)) bus_rdata = st_q.mat[n];
            end
        end
    end

    assign merged = alias_merge(bus_rdata, bus_wdata, op, sel == SEL_FLAG);

    always_comb begin
        st_d = st_q;
        if (bus_we && aligned) begin
            unique case (sel)
                SEL_FLAG: st_d.flag = merged[CH_N-1:0];
                SEL_CTRL: st_d.ctrl = merged[2*CH_N-1:0];
                SEL_DIR:  st_d.dir  = merged[DIR_FW*CH_N-1:0];
                SEL_PRE:  st_d.pre  = merged;
                SEL_MCTL: st_d.mctl = merged[ACT_W*CH_N-1:0];
                default:  ;
            endcase
            for (int n = 0; n < CH_N; n++) begin
                if (sel == 4'(int'(SEL_MAT0) + n)) st_d.mat[n] = merged;
            end
        end
        // Hardware events take priority over the bus on the same edge.
        st_d.ctrl[CH_N-1:0] = st_d.ctrl[CH_N-1:0] & ~stop_vec;
        st_d.flag           = st_d.flag | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |st_q.flag;

    // R7: flags move only through a match or a bus write
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !bus_we) |=> $stable(st_q.flag));

    // R7: a match with its interrupt bit always leaves the flag set
    p_flag_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((st_q.flag & $past(flag_set)) == $past(flag_set)));
endmodule

// File: tb/mtimer_top_tb_top.sv
`timescale 1ns/1ps
module mtimer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ba = 8'h0;
    logic        bw = 1'b0;
    logic [31:0] bd = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    mtimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(ba), .bus_we(bw),
        .bus_wdata(bd), .bus_rdata(rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_tc [4];
    logic [31:0] m_mr [4];
    logic [7:0]  m_ctrl = '0;
    logic [15:0] m_dir = '0;
    logic [31:0] m_pr = '0, m_pc = '0;
    logic [11:0] m_mcr = '0;
    logic [3:0]  m_ir = '0;

    initial for (int i = 0; i < 4; i++) begin m_tc[i] = 0; m_mr[i] = 0; end

    function automatic logic [31:0] mread(input logic [7:0] a);
        int s = int'(a[7:4]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (s == 0) return {28'h0, m_ir};
        if (s == 1) return {24'h0, m_ctrl};
        if (s == 2) return {16'h0, m_dir};
        if (s >= 3 && s <= 6) return m_tc[s-3];
        if (s == 7) return m_pr;
        if (s == 8) return m_pc;
        if (s == 9) return {20'h0, m_mcr};
        if (s >= 10 && s <= 13) return m_mr[s-10];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_tc[i] = 0; m_mr[i] = 0; end
            m_ctrl = 0; m_dir = 0; m_pr = 0; m_pc = 0; m_mcr = 0; m_ir = 0;
        end else begin
            logic [3:0]  act, fset, stopm;
            logic [31:0] ntc [4];
            logic [31:0] npc, old, nv;
            bit          tk;
            int          s;
            act   = m_ctrl[3:0] & ~m_ctrl[7:4];
            tk    = (act != 0) && (m_pc >= m_pr);
            npc   = (act == 0 || tk) ? 32'h0 : m_pc + 1;
            fset  = 0;
            stopm = 0;
            for (int n = 0; n < 4; n++) begin
                logic [31:0] nxt;
                nxt = (((m_dir >> (4*n)) & 16'hF) == 1) ? m_tc[n] - 1 : m_tc[n] + 1;
                ntc[n] = m_tc[n];
                if (m_ctrl[4+n]) ntc[n] = 0;
                else if (act[n] && tk) begin
                    if (m_tc[n] == m_mr[n]) begin
                        if (m_mcr[3*n])   fset[n]  = 1'b1;
                        if (m_mcr[3*n+2]) stopm[n] = 1'b1;
                        if (m_mcr[3*n+1])      ntc[n] = 0;
                        else if (!m_mcr[3*n+2]) ntc[n] = nxt;
                    end else ntc[n] = nxt;
                end
            end
            if (bw && ba[1:0] == 2'b00) begin
                old = mread(ba);
                s = int'(ba[7:4]);
                case (ba[3:2])
                    2'd0: nv = (s == 0) ? (old & ~bd) : bd;
                    2'd1: nv = old | bd;
                    2'd2: nv = old & ~bd;
                    default: nv = old ^ bd;
                endcase
                if (s == 0) m_ir = nv[3:0];
                if (s == 1) m_ctrl = nv[7:0];
                if (s == 2) m_dir = nv[15:0];
                if (s == 7) m_pr = nv;
                if (s == 9) m_mcr = nv[11:0];
                if (s >= 10 && s <= 13) m_mr[s-10] = nv;
            end
            m_ctrl[3:0] = m_ctrl[3:0] & ~stopm;
            m_ir = m_ir | fset;
            m_pc = npc;
            for (int n = 0; n < 4; n++) m_tc[n] = ntc[n];
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            checks++;
            if (rdata !== mread(ba)) begin
                errors++;
                $display("FAIL %s model read addr=%h actual=%h expected=%h", cur_req, ba, rdata, mread(ba));
            end
            checks++;
            if (irq !== (m_ir != 0)) begin
                errors++;
                $display("FAIL R8 model irq actual=%b expected=%b", irq, (m_ir != 0));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); ba = a; bw = 1'b1; bd = d;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin @(negedge clk); bw = 1'b0; end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp,
                      input logic [31:0] m, input string tag);
        @(negedge clk); bw = 1'b0; ba = a;
        #1;
        checks++;
        if ((rdata & m) !== exp) begin
            errors++;
            $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, rdata & m, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        for (int s = 0; s < 16; s++) rd(8'(s << 4), 32'h0, 32'hFFFF_FFFF, "R10");
        chk_irq(1'b0, "R10");

        // R1: write styles on a match register
        cur_req = "R1";
        wr(8'hA0, 32'h0F0F); wr(8'hA4, 32'hF000);
        rd(8'hA0, 32'hFF0F, 32'hFFFF_FFFF, "R1");
        wr(8'hA8, 32'h000F);
        rd(8'hA0, 32'hFF00, 32'hFFFF_FFFF, "R1");
        wr(8'hAC, 32'h0FF0);
        rd(8'hA0, 32'hF0F0, 32'hFFFF_FFFF, "R1");
        rd(8'hA4, 32'hF0F0, 32'hFFFF_FFFF, "R1");

        // R2: enable gates counting
        cur_req = "R2";
        wr(8'h14, 32'h1); idle(9); wr(8'h18, 32'h1);
        rd(8'h30, 32'd10, 32'hFFFF_FFFF, "R2");
        idle(5);
        rd(8'h30, 32'd10, 32'hFFFF_FFFF, "R2");

        // R3: hold-in-reset
        cur_req = "R3";
        wr(8'h14, 32'h11); idle(3);
        rd(8'h30, 32'd0, 32'hFFFF_FFFF, "R3");
        wr(8'h18, 32'h10); idle(2); wr(8'h18, 32'h1);
        rd(8'h30, 32'd3, 32'hFFFF_FFFF, "R3");

        // R4 and R7: down count wraps below zero without a flag
        cur_req = "R4";
        wr(8'h20, 32'h10); wr(8'hB0, 32'h1234); wr(8'h94, 32'h8);
        wr(8'h14, 32'h2); idle(1); wr(8'h18, 32'h2);
        rd(8'h40, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4");
        rd(8'h00, 32'h0, 32'h2, "R7");
        wr(8'h20, 32'h20);
        wr(8'h14, 32'h2); wr(8'h18, 32'h2);
        rd(8'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        wr(8'h14, 32'h2); wr(8'h18, 32'h2);
        rd(8'h40, 32'h0, 32'hFFFF_FFFF, "R4");
        rd(8'h00, 32'h0, 32'hF, "R7");

        // R5: prescaler with limit 3
        cur_req = "R5";
        wr(8'h70, 32'd3); wr(8'h14, 32'h4); idle(7);
        rd(8'h80, 32'd3, 32'hFFFF_FFFF, "R5");
        rd(8'h50, 32'd2, 32'hFFFF_FFFF, "R5");
        wr(8'h18, 32'h4); wr(8'h70, 32'd0);

        // R6: periodic match on counter 0
        cur_req = "R6";
        wr(8'hA0, 32'd5); wr(8'h90, 32'h3);
        wr(8'h14, 32'h10); idle(1); wr(8'h18, 32'h10);
        wr(8'h14, 32'h1); idle(13); wr(8'h18, 32'h1);
        rd(8'h30, 32'd2, 32'hFFFF_FFFF, "R6");
        rd(8'h00, 32'h1, 32'h1, "R6");
        chk_irq(1'b1, "R8");

        // R7 and R8: flag register write styles
        cur_req = "R7";
        wr(8'h00, 32'h1);
        rd(8'h00, 32'h0, 32'hFFFF_FFFF, "R7");
        chk_irq(1'b0, "R8");
        wr(8'h04, 32'h4);
        rd(8'h00, 32'h4, 32'hFFFF_FFFF, "R7");
        chk_irq(1'b1, "R8");
        wr(8'h0C, 32'h6);
        rd(8'h00, 32'h2, 32'hFFFF_FFFF, "R7");
        wr(8'h08, 32'h2); wr(8'h04, 32'h10);
        rd(8'h00, 32'h0, 32'hFFFF_FFFF, "R7");

        // R6: stop action on counter 3
        cur_req = "R6";
        wr(8'hD0, 32'd4); wr(8'h94, 32'hA00);
        wr(8'h14, 32'h8); idle(10);
        rd(8'h60, 32'd4, 32'hFFFF_FFFF, "R6");
        rd(8'h10, 32'h0, 32'h8, "R6");
        rd(8'h00, 32'h8, 32'h8, "R6");
        chk_irq(1'b1, "R8");

        // R9: read-only and unmapped addresses
        cur_req = "R9";
        wr(8'h30, 32'h55);
        rd(8'h30, 32'd2, 32'hFFFF_FFFF, "R9");
        wr(8'hE0, 32'hFFFF);
        rd(8'hE0, 32'h0, 32'hFFFF_FFFF, "R9");
        rd(8'hF4, 32'h0, 32'hFFFF_FFFF, "R9");
        wr(8'h84, 32'h7);
        rd(8'h80, 32'h0, 32'hFFFF_FFFF, "R9");
        wr(8'hA1, 32'h77);
        rd(8'hA1, 32'h0, 32'hFFFF_FFFF, "R9");
        rd(8'hA0, 32'd5, 32'hFFFF_FFFF, "R9");

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule